// File: doc/BRIEF.md
# USB IN Endpoint Transmit Controller

This block is the device-side transmit controller for one bulk or interrupt IN endpoint. A local CPU reads how much room the transmit FIFO has, writes up to that many bytes into it, and then arms the packet. When the serial engine reports a decoded IN token, the block either streams the armed packet out one byte per clock, or asks the engine to send a NAK handshake if nothing is armed.

After a packet has gone out, the block waits for the engine to report whether the host answered. An ACK commits the data, frees the FIFO, disarms the endpoint, flips the data toggle and raises a success flag. A missing handshake leaves the packet in place, so the next IN token sends the same bytes again with the same toggle. Every NAK that is caused by an unarmed or empty FIFO raises a fail flag, which prompts the CPU to refill the FIFO. Each flag has an enable and a routing bit. The routing bit places the flag's interrupt either on the shared endpoint line or on a line of its own, so software does not have to poll for the source.

Top module: `usb_in_ep_tx`

## Requirements
- R1: After reset, `armed`, `fail_flag`, `ok_flag`, `tx_valid`, `tx_nak` and `tx_pid1` are all 0, and `free_cnt` equals DEPTH (8).
- R2: An IN token that arrives while the block is idle and the FIFO is unarmed or empty produces a one-cycle `tx_nak` pulse in the cycle after the token. No data is sent, and `fail_flag` is set in the same cycle.
- R3: `free_cnt` is always DEPTH minus the number of stored bytes. A write is ignored when the endpoint is armed or the FIFO holds DEPTH bytes.
- R4: An `arm` pulse sets `armed`, and `armed` stays set until an ACK is taken.
- R5: An IN token that arrives while the block is idle, armed and non-empty starts the packet in the next cycle. The stored bytes go out in write order, one per cycle with `tx_valid` high, and `tx_last` is high only on the final byte. The packet length is the number of stored bytes, at most 8.
- R6: A `hs_ack` pulse taken after the final byte does four things in the next cycle: it clears `armed`, returns `free_cnt` to DEPTH, sets `ok_flag` and inverts `tx_pid1`, where 0 means DATA0 and 1 means DATA1.
- R7: A `hs_timeout` pulse taken after the final byte leaves `armed`, the stored bytes, the flags and `tx_pid1` unchanged. The next IN token resends the identical packet.
- R8: IN tokens that arrive while a packet is being sent or awaits its handshake are ignored. Handshake pulses that arrive while the block is idle or still sending are ignored.
- R9: `fail_flag` and `ok_flag` stay set until a `clr_fail` or `clr_ok` pulse clears them. If a set and a clear fall in the same cycle, the set wins.
- R10: `irq_ep` is the OR of (`fail_flag` AND `ie_fail` AND NOT `route_fail`) and (`ok_flag` AND `ie_ok` AND NOT `route_ok`). `irq_fail` is `fail_flag` AND `ie_fail` AND `route_fail`. `irq_ok` is `ok_flag` AND `ie_ok` AND `route_ok`.
- R11: A `bus_reset` pulse returns `tx_pid1` to 0 (DATA0) in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_reset | input | 1 | USB bus reset seen, resets data toggle |
| wr_en | input | 1 | CPU FIFO write strobe |
| wr_data | input | 8 | CPU FIFO write byte |
| free_cnt | output | 4 | Free FIFO bytes |
| arm | input | 1 | CPU strobe that makes the FIFO contents eligible to send |
| armed | output | 1 | Packet armed |
| clr_fail | input | 1 | Clear strobe for fail flag |
| clr_ok | input | 1 | Clear strobe for success flag |
| ie_fail | input | 1 | Fail interrupt enable |
| ie_ok | input | 1 | Success interrupt enable |
| route_fail | input | 1 | 1 routes fail to its own line, 0 to shared line |
| route_ok | input | 1 | 1 routes success to its own line, 0 to shared line |
| fail_flag | output | 1 | Sticky NAK-on-empty flag |
| ok_flag | output | 1 | Sticky acknowledged-transfer flag |
| irq_ep | output | 1 | Shared endpoint interrupt |
| irq_fail | output | 1 | Dedicated fail interrupt |
| irq_ok | output | 1 | Dedicated success interrupt |
| tok_in | input | 1 | Decoded IN token pulse |
| hs_ack | input | 1 | ACK handshake received pulse |
| hs_timeout | input | 1 | No handshake received pulse |
| tx_valid | output | 1 | Data byte valid toward serial engine |
| tx_data | output | 8 | Data byte |
| tx_last | output | 1 | Final byte of packet |
| tx_pid1 | output | 1 | Data toggle, 0 = DATA0, 1 = DATA1 |
| tx_nak | output | 1 | Send NAK handshake pulse |

## Verification
The case that is hardest to bring about is a retransmission whose bytes and toggle must match the failed attempt exactly. A retransmission only happens when a timeout follows a packet. The same test must also show that a token arriving mid-packet does not restart or corrupt the stream. The bench reaches these cases with seeded random packets of random length, and on a random half of them it injects a timeout before the ACK, so both outcomes occur many times. Directed steps add a token during streaming, handshakes while idle, a write past full, a write while armed, a flag set and clear in the same cycle, and a bus reset that falls between toggles.

// File: rtl/usb_in_ep_tx.sv
`timescale 1ns/1ps
module usb_in_ep_tx #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_reset,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  output logic [$clog2(DEPTH+1)-1:0]   free_cnt,
  input  logic                         arm,
  output logic                         armed,
  input  logic                         clr_fail,
  input  logic                         clr_ok,
  input  logic                         ie_fail,
  input  logic                         ie_ok,
  input  logic                         route_fail,
  input  logic                         route_ok,
  output logic                         fail_flag,
  output logic                         ok_flag,
  output logic                         irq_ep,
  output logic                         irq_fail,
  output logic                         irq_ok,
  input  logic                         tok_in,
  input  logic                         hs_ack,
  input  logic                         hs_timeout,
  output logic                         tx_valid,
  output logic [DW-1:0]                tx_data,
  output logic                         tx_last,
  output logic                         tx_pid1,
  output logic                         tx_nak
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  typedef enum logic [1:0] {IDLE, SEND, WAIT} st_t;
  st_t st;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, sh_ptr;
  logic [CW-1:0] count, rem;

  wire busy     = (st != IDLE);
  wire tok_idle = tok_in && (st == IDLE);
  wire can_send = armed && (count != '0);
  wire start    = tok_idle && can_send;
  wire nak_hit  = tok_idle && !can_send;
  wire ack_hit  = (st == WAIT) && hs_ack;
  wire tmo_hit  = (st == WAIT) && !hs_ack && hs_timeout;
  wire wr_ok    = wr_en && !armed && (count < CW'(DEPTH));

  assign free_cnt = CW'(DEPTH) - count;
  assign tx_valid = (st == SEND);
  assign tx_data  = mem[sh_ptr];
  assign tx_last  = (st == SEND) && (rem == CW'(1));

  assign irq_ep   = (fail_flag && ie_fail && !route_fail) || (ok_flag && ie_ok && !route_ok);
  assign irq_fail = fail_flag && ie_fail && route_fail;
  assign irq_ok   = ok_flag && ie_ok && route_ok;

  always_ff @(posedge clk)
    if (wr_ok) mem[wr_ptr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      count  <= '0;
    end else if (ack_hit) begin
      count  <= '0;
    end else if (wr_ok) begin
      wr_ptr <= wr_ptr + AW'(1);
      count  <= count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      rd_ptr <= '0;
      sh_ptr <= '0;
      rem    <= '0;
    end else begin
      unique case (st)
        IDLE: if (start) begin
          st     <= SEND;
          sh_ptr <= rd_ptr;
          rem    <= count;
        end
        SEND: begin
          sh_ptr <= sh_ptr + AW'(1);
          rem    <= rem - CW'(1);
          if (rem == CW'(1)) st <= WAIT;
        end
        WAIT: begin
          if (ack_hit) begin
            rd_ptr <= sh_ptr;
            st     <= IDLE;
          end else if (tmo_hit) begin
            sh_ptr <= rd_ptr;
            st     <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      fail_flag <= 1'b0;
      ok_flag   <= 1'b0;
      tx_nak    <= 1'b0;
      tx_pid1   <= 1'b0;
    end else begin
      tx_nak    <= nak_hit;
      fail_flag <= (fail_flag && !clr_fail) || nak_hit;
      ok_flag   <= (ok_flag && !clr_ok) || ack_hit;
      if (ack_hit)   armed <= 1'b0;
      else if (arm)  armed <= 1'b1;
      if (bus_reset)    tx_pid1 <= 1'b0;
      else if (ack_hit) tx_pid1 <= !tx_pid1;
    end
  end
endmodule

module usb_in_ep_tx_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       busy,
  input logic                       tok_in,
  input logic                       hs_ack,
  input logic                       bus_reset,
  input logic                       armed,
  input logic [$clog2(DEPTH+1)-1:0] free_cnt,
  input logic                       fail_flag,
  input logic                       ok_flag,
  input logic                       clr_fail,
  input logic                       ie_fail,
  input logic                       route_fail,
  input logic                       irq_fail,
  input logic                       tx_valid,
  input logic                       tx_nak,
  input logic                       tx_pid1
);
  localparam int CW = $clog2(DEPTH+1);
  wire unsendable = !armed || (free_cnt == CW'(DEPTH));

  // R2
  nak_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_in && !busy && unsendable |=> tx_nak && fail_flag && !tx_valid);
  // R8
  nak_data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_nak && tx_valid));
  // R6
  ack_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tx_valid && hs_ack && !bus_reset |=> !armed && ok_flag && free_cnt == CW'(DEPTH)
      && tx_pid1 != $past(tx_pid1));
  // R11
  pid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && !tx_valid && hs_ack) && !bus_reset |=> $stable(tx_pid1));
  // R11
  pid_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !tx_pid1);
  // R3
  free_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CW'(DEPTH));
  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag && !clr_fail |=> fail_flag);
  // R10
  irq_fail_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fail |-> fail_flag && ie_fail && route_fail);
endmodule

bind usb_in_ep_tx usb_in_ep_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tok_in(tok_in), .hs_ack(hs_ack),
  .bus_reset(bus_reset), .armed(armed), .free_cnt(free_cnt), .fail_flag(fail_flag),
  .ok_flag(ok_flag), .clr_fail(clr_fail), .ie_fail(ie_fail), .route_fail(route_fail),
  .irq_fail(irq_fail), .tx_valid(tx_valid), .tx_nak(tx_nak), .tx_pid1(tx_pid1)
);

// File: tb/tb_usb_in_ep_tx.sv
`timescale 1ns/1ps
module tb_usb_in_ep_tx;
  logic clk = 0, rst_n = 0, bus_reset = 0, wr_en = 0, arm = 0;
  logic clr_fail = 0, clr_ok = 0, ie_fail = 0, ie_ok = 0, route_fail = 0, route_ok = 0;
  logic tok_in = 0, hs_ack = 0, hs_timeout = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] free_cnt;
  logic armed, fail_flag, ok_flag, irq_ep, irq_fail, irq_ok;
  logic tx_valid, tx_last, tx_pid1, tx_nak;
  logic [7:0] tx_data;

  usb_in_ep_tx dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] mq [8];
  int mn = 0;
  bit mpid = 0, mfail = 0, mok = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic bit exp_irq_ep(bit f, bit o);
    return (f && ie_fail && !route_fail) || (o && ie_ok && !route_ok);
  endfunction

  task automatic check_irq();
    chk("R10 irq_ep", irq_ep, exp_irq_ep(mfail, mok));
    chk("R10 irq_fail", irq_fail, mfail && ie_fail && route_fail);
    chk("R10 irq_ok", irq_ok, mok && ie_ok && route_ok);
  endtask

  task automatic write_byte(logic [7:0] b, bit locked);
    wr_en = 1; wr_data = b; step(); wr_en = 0;
    if (!locked && mn < 8) begin mq[mn] = b; mn++; end
    chk("R3 free_cnt", free_cnt, 8 - mn);
  endtask

  task automatic nak_token();
    tok_in = 1; step(); tok_in = 0;
    mfail = 1;
    chk("R2 nak pulse", tx_nak, 1);
    chk("R2 no data", tx_valid, 0);
    chk("R2 fail flag", fail_flag, 1);
    step();
    chk("R2 nak one cycle", tx_nak, 0);
  endtask

  task automatic packet_token(bit poke);
    tok_in = 1; step(); tok_in = 0;
    for (int i = 0; i < mn; i++) begin
      chk("R5 valid", tx_valid, 1);
      chk("R5 data", tx_data, mq[i]);
      chk("R5 last", tx_last, i == mn - 1);
      chk("R5 pid", tx_pid1, mpid);
      if (poke && i == 0) begin tok_in = 1; hs_ack = 1; end
      step();
      tok_in = 0; hs_ack = 0;
    end
    chk("R5 end of packet", tx_valid, 0);
    chk("R8 no nak mid packet", tx_nak, 0);
  endtask

  task automatic do_ack();
    hs_ack = 1; step(); hs_ack = 0;
    mn = 0; mpid = !mpid; mok = 1;
    chk("R6 disarm", armed, 0);
    chk("R6 free restored", free_cnt, 8);
    chk("R6 ok flag", ok_flag, 1);
    chk("R6 toggle", tx_pid1, mpid);
  endtask

  task automatic do_timeout();
    hs_timeout = 1; step(); hs_timeout = 0;
    chk("R7 still armed", armed, 1);
    chk("R7 data kept", free_cnt, 8 - mn);
    chk("R7 pid kept", tx_pid1, mpid);
    chk("R7 ok unchanged", ok_flag, mok);
  endtask

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    step(); step();
    rst_n = 1; step();
    chk("R1 armed", armed, 0);
    chk("R1 fail", fail_flag, 0);
    chk("R1 ok", ok_flag, 0);
    chk("R1 valid", tx_valid, 0);
    chk("R1 nak", tx_nak, 0);
    chk("R1 pid", tx_pid1, 0);
    chk("R1 free", free_cnt, 8);

    nak_token();
    hs_ack = 1; step(); hs_timeout = 1; hs_ack = 0; step(); hs_timeout = 0;
    chk("R8 idle ack ignored", ok_flag, 0);
    chk("R8 idle ack pid", tx_pid1, 0);

    arm = 1; step(); arm = 0;
    chk("R4 armed", armed, 1);
    nak_token();
    arm = 0;
    rst_n = 0; step(); rst_n = 1; step();
    mfail = 0;

    for (int i = 0; i < 9; i++) write_byte(8'(8'hA0 + i), 0);
    chk("R3 full ignored", free_cnt, 0);
    arm = 1; step(); arm = 0;
    write_byte(8'hFF, 1);
    chk("R3 armed write ignored", free_cnt, 0);
    packet_token(1);
    chk("R8 ack during send ignored", ok_flag, 0);
    do_timeout();
    packet_token(0);
    do_ack();

    clr_fail = 1; tok_in = 1; step(); clr_fail = 0; tok_in = 0;
    chk("R9 set wins", fail_flag, 1);
    step();
    clr_fail = 1; step(); clr_fail = 0; mfail = 0;
    chk("R9 fail cleared", fail_flag, 0);
    chk("R9 ok sticky", ok_flag, 1);
    clr_ok = 1; step(); clr_ok = 0; mok = 0;
    chk("R9 ok cleared", ok_flag, 0);

    bus_reset = 1; step(); bus_reset = 0; mpid = 0;
    chk("R11 pid reset", tx_pid1, 0);

    for (int it = 0; it < 60; it++) begin
      int n;
      if ($urandom_range(0, 3) == 0) nak_token();
      n = $urandom_range(1, 8);
      for (int k = 0; k < n; k++) write_byte(8'($urandom), 0);
      arm = 1; step(); arm = 0;
      chk("R4 armed", armed, 1);
      packet_token(0);
      if ($urandom_range(0, 1) == 1) begin
        do_timeout();
        packet_token(0);
      end
      do_ack();
      ie_fail = 1'($urandom); ie_ok = 1'($urandom);
      route_fail = 1'($urandom); route_ok = 1'($urandom);
      #1; check_irq();
      if ($urandom_range(0, 1) == 1) begin clr_ok = 1; step(); clr_ok = 0; mok = 0; end
      if ($urandom_range(0, 1) == 1) begin clr_fail = 1; step(); clr_fail = 0; mfail = 0; end
      #1; check_irq();
      if ($urandom_range(0, 7) == 0) begin
        bus_reset = 1; step(); bus_reset = 0; mpid = 0;
        chk("R11 pid reset", tx_pid1, 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule